// File: doc/BRIEF.md
# Floating-Point Exception Status Arbiter

This block sits beside a floating-point datapath and decides, for every issued FP instruction, what happens to its result and whether the core must take a trap. The datapath supplies the operation kind, a class code and sign for each of the two operands, and a vector of rounding status flags. Together with the per-exception enable bits, the block keeps the exception cause field, decides whether the result may be written back (and whether a quiet NaN must replace it), and raises a trap request with a vector code that stays put until the core acknowledges it.

Only one cause is ever recorded per operation. Invalid operations are checked first, then divide-by-zero, then the rounding flags in a fixed order, and a condition whose enable is off does not block a lower one. An enabled exception suppresses the writeback instead of yielding a default result. Instructions issued with the FPU switched off, or with an opcode the FPU does not implement, never execute and trap with their own codes.

Top module: `fpx_exc_arbiter`

## Requirements
- R1: After reset every output is 0. Each executed operation (op_valid with fpu_en high and unimpl low) clears the cause field before recording, so at most one cause bit is ever set. Cause and enable bit positions: bit0 inexact, bit1 underflow, bit2 overflow, bit3 divide-by-zero, bit4 invalid.
- R2: Class codes are 0 zero, 1 finite nonzero, 2 infinity, 3 quiet NaN, 4 signaling NaN; kind codes are 0 add, 1 subtract, 2 multiply, 3 divide, 4 other. An operation is invalid when either operand is a signaling NaN, or for add two infinities of opposite sign, for subtract two infinities of equal sign, for multiply infinity with zero in either order, for divide zero by zero or infinity by infinity. An invalid operation with the invalid enable set records the invalid cause and is not written back.
- R3: An invalid operation with the invalid enable clear is written back with op_qnan_o high (quiet NaN substituted) and records no cause.
- R4: A divide of a finite nonzero value by zero with the divide-by-zero enable set records that cause and is not written back; with that enable clear the result goes through the status check of R5.
- R5: Status bits: bit0 overflow, bit1 underflow, bit2 denormal, bit3 inexact, bit4 rounded. Overflow is tested first, then underflow-or-denormal, then inexact-or-rounded; only the first of these whose enable is set records its cause.
- R6: An executed operation that records no cause is written back (op_wb_o high, op_qnan_o low unless R3 applies); an operation that records a cause is not.
- R7: An executed operation that ends with a nonzero cause field raises a trap with code 0x1D0.
- R8: An op issued with fpu_en low traps with code 0x1C0; one issued with fpu_en high and unimpl high traps with code 0x1C8. Neither is written back, pulses op_done_o, or changes the cause field.
- R9: trap_req_o and trap_code_o are registered and hold their values until trap_ack; a trap raised while another is pending and unacknowledged is dropped.
- R10: Any status bit at position 5 or above on an executed operation sets stat_err_o, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | One FP instruction issued this cycle |
| op_kind | input | 3 | Operation kind code |
| cls_a | input | 3 | Class code of operand A |
| sgn_a | input | 1 | Sign of operand A |
| cls_b | input | 3 | Class code of operand B |
| sgn_b | input | 1 | Sign of operand B |
| dp_status | input | STAT_W | Rounding status flags from the datapath |
| exc_enable | input | 5 | Per-exception enable bits |
| fpu_en | input | 1 | FPU-enable bit of the processor status word |
| unimpl | input | 1 | Opcode is not implemented by the FPU |
| trap_ack | input | 1 | Core acknowledges the pending trap |
| op_done_o | output | 1 | Pulses one cycle after an executed operation |
| op_wb_o | output | 1 | Result may be written back |
| op_qnan_o | output | 1 | Write a quiet NaN instead of the datapath result |
| cause_o | output | 5 | Current exception cause field |
| trap_req_o | output | 1 | Trap request, held until acknowledged |
| trap_code_o | output | CODE_W | Trap vector code |
| stat_err_o | output | 1 | Sticky unrecognised-status flag |

## Verification
The bench sweeps every enable pattern against every known status pattern, and every class, sign and kind combination against every enable pattern, so a priority chain that stopped at a disabled overflow instead of falling through to underflow, or that ignored denormal or rounded flags, would record the wrong cause or write back a result it should have held. The invalid sweep catches a design that swapped the sign rule between add and subtract, or that treated zero over zero as a divide-by-zero, by showing the Z cause or a written result where the invalid path belongs. Directed sequences check that a disabled FPU outranks an unimplemented opcode, that such traps leave the cause field untouched, and that a second trap cannot overwrite a pending code before the acknowledge.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int CAUSE_W    = 5;
    localparam int KNOWN_STAT = 5;

    // cause / enable bit positions
    localparam int CB_I = 0;
    localparam int CB_U = 1;
    localparam int CB_O = 2;
    localparam int CB_Z = 3;
    localparam int CB_V = 4;

    // datapath status bit positions
    localparam int SB_OVF = 0;
    localparam int SB_UNF = 1;
    localparam int SB_DEN = 2;
    localparam int SB_INX = 3;
    localparam int SB_RND = 4;

    typedef enum logic [2:0] {
        CLS_ZERO   = 3'd0,
        CLS_FINITE = 3'd1,
        CLS_INF    = 3'd2,
        CLS_QNAN   = 3'd3,
        CLS_SNAN   = 3'd4
    } fp_class_e;

    typedef enum logic [2:0] {
        OPK_ADD   = 3'd0,
        OPK_SUB   = 3'd1,
        OPK_MUL   = 3'd2,
        OPK_DIV   = 3'd3,
        OPK_OTHER = 3'd4
    } op_kind_e;

    typedef struct packed {
        logic [CAUSE_W-1:0] cause;
        logic               wb;
        logic               qnan;
        logic               done;
        logic               err;
    } arb_state_t;

endpackage

// File: rtl/fpx_invalid_detect.sv
module fpx_invalid_detect
    import fpx_pkg::*;
(
    input  logic [2:0] op_kind,
    input  logic [2:0] cls_a,
    input  logic       sgn_a,
    input  logic [2:0] cls_b,
    input  logic       sgn_b,
    output logic       invalid,
    output logic       div_zero
);

    logic a_inf, b_inf, a_zero, b_zero, any_snan;
    logic bad_add, bad_sub, bad_mul, bad_div;

    always_comb begin
        a_inf    = (cls_a == CLS_INF);
        b_inf    = (cls_b == CLS_INF);
        a_zero   = (cls_a == CLS_ZERO);
        b_zero   = (cls_b == CLS_ZERO);
        any_snan = (cls_a == CLS_SNAN) || (cls_b == CLS_SNAN);

        bad_add = a_inf && b_inf && (sgn_a != sgn_b);
        bad_sub = a_inf && b_inf && (sgn_a == sgn_b);
        bad_mul = (a_inf && b_zero) || (a_zero && b_inf);
        bad_div = (a_zero && b_zero) || (a_inf && b_inf);

        invalid = any_snan;
        unique case (op_kind)
            OPK_ADD: invalid = any_snan || bad_add;
            OPK_SUB: invalid = any_snan || bad_sub;
            OPK_MUL: invalid = any_snan || bad_mul;
            OPK_DIV: invalid = any_snan || bad_div;
            default: invalid = any_snan;
        endcase

        div_zero = (op_kind == OPK_DIV) && (cls_a == CLS_FINITE) && b_zero;
    end

endmodule

// File: rtl/fpx_status_prio.sv
module fpx_status_prio
    import fpx_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic [STAT_W-1:0]  status,
    input  logic [CAUSE_W-1:0] enable,
    output logic [CAUSE_W-1:0] hit,
    output logic               unknown
);

    logic ovf_c, unf_c, inx_c;

    always_comb begin
        ovf_c = status[SB_OVF];
        unf_c = status[SB_UNF] || status[SB_DEN];
        inx_c = status[SB_INX] || status[SB_RND];
        hit   = '0;
        if (ovf_c && enable[CB_O]) begin
            hit[CB_O] = 1'b1;
        end else if (unf_c && enable[CB_U]) begin
            hit[CB_U] = 1'b1;
        end else if (inx_c && enable[CB_I]) begin
            hit[CB_I] = 1'b1;
        end
    end

    generate
        if (STAT_W > KNOWN_STAT) begin : g_extra
            assign unknown = |status[STAT_W-1:KNOWN_STAT];
        end else begin : g_none
            assign unknown = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/fpx_trap_hold.sv
module fpx_trap_hold #(
    parameter int CODE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raise,
    input  logic [CODE_W-1:0] code_in,
    input  logic              ack,
    output logic              req_q,
    output logic [CODE_W-1:0] code_q
);

    typedef struct packed {
        logic              req;
        logic [CODE_W-1:0] code;
    } trap_t;

    trap_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (cur_q.req && !ack) begin
            nxt_d = cur_q;
        end else if (raise) begin
            nxt_d.req  = 1'b1;
            nxt_d.code = code_in;
        end else begin
            nxt_d.req  = 1'b0;
            nxt_d.code = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign req_q  = cur_q.req;
    assign code_q = cur_q.code;

    a_r9_trap_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !ack) |=> (req_q && $stable(code_q)));

    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && ack && !raise) |=> !req_q);

endmodule

// File: rtl/fpx_exc_arbiter.sv
module fpx_exc_arbiter
    import fpx_pkg::*;
#(
    parameter int              STAT_W      = 8,
    parameter int              CODE_W      = 9,
    parameter logic [CODE_W-1:0] CODE_ARITH  = 9'h1D0,
    parameter logic [CODE_W-1:0] CODE_OFF    = 9'h1C0,
    parameter logic [CODE_W-1:0] CODE_UNIMPL = 9'h1C8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [2:0]         op_kind,
    input  logic [2:0]         cls_a,
    input  logic               sgn_a,
    input  logic [2:0]         cls_b,
    input  logic               sgn_b,
    input  logic [STAT_W-1:0]  dp_status,
    input  logic [4:0]         exc_enable,
    input  logic               fpu_en,
    input  logic               unimpl,
    input  logic               trap_ack,
    output logic               op_done_o,
    output logic               op_wb_o,
    output logic               op_qnan_o,
    output logic [4:0]         cause_o,
    output logic               trap_req_o,
    output logic [CODE_W-1:0]  trap_code_o,
    output logic               stat_err_o
);

    arb_state_t         st_q, st_d;
    logic               invalid, div_zero, unknown;
    logic [CAUSE_W-1:0] hit;
    logic               raise_d;
    logic [CODE_W-1:0]  code_d;

    fpx_invalid_detect u_inv (
        .op_kind  (op_kind),
        .cls_a    (cls_a),
        .sgn_a    (sgn_a),
        .cls_b    (cls_b),
        .sgn_b    (sgn_b),
        .invalid  (invalid),
        .div_zero (div_zero)
    );

    fpx_status_prio #(.STAT_W(STAT_W)) u_prio (
        .status  (dp_status),
        .enable  (exc_enable),
        .hit     (hit),
        .unknown (unknown)
    );

    always_comb begin
        st_d      = st_q;
        st_d.wb   = 1'b0;
        st_d.qnan = 1'b0;
        st_d.done = 1'b0;
        raise_d   = 1'b0;
        code_d    = '0;
        if (op_valid) begin
            if (!fpu_en) begin
                raise_d = 1'b1;
                code_d  = CODE_OFF;
            end else if (unimpl) begin
                raise_d = 1'b1;
                code_d  = CODE_UNIMPL;
            end else begin
                st_d.done  = 1'b1;
                st_d.cause = '0;
                if (invalid) begin
                    if (exc_enable[CB_V]) begin
                        st_d.cause[CB_V] = 1'b1;
                    end else begin
                        st_d.wb   = 1'b1;
                        st_d.qnan = 1'b1;
                    end
                end else if (div_zero && exc_enable[CB_Z]) begin
                    st_d.cause[CB_Z] = 1'b1;
                end else begin
                    st_d.cause = hit;
                    st_d.wb    = (hit == '0);
                end
                if (unknown) begin
                    st_d.err = 1'b1;
                end
                if (st_d.cause != '0) begin
                    raise_d = 1'b1;
                    code_d  = CODE_ARITH;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    fpx_trap_hold #(.CODE_W(CODE_W)) u_trap (
        .clk     (clk),
        .rst_n   (rst_n),
        .raise   (raise_d),
        .code_in (code_d),
        .ack     (trap_ack),
        .req_q   (trap_req_o),
        .code_q  (trap_code_o)
    );

    assign op_done_o  = st_q.done;
    assign op_wb_o    = st_q.wb;
    assign op_qnan_o  = st_q.qnan;
    assign cause_o    = st_q.cause;
    assign stat_err_o = st_q.err;

    a_r1_one_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cause_o));

    a_r6_no_wb_with_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done_o && (cause_o != '0)) |-> !op_wb_o);

    a_r3_qnan_needs_wb: assert property (@(posedge clk) disable iff (!rst_n)
        op_qnan_o |-> (op_wb_o && op_done_o));

    a_r7_cause_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done_o && (cause_o != '0)) |-> trap_req_o);

    a_r8_off_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !fpu_en) |=> (!op_wb_o && !op_done_o && trap_req_o && $stable(cause_o)));

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stat_err_o |=> stat_err_o);

endmodule

// File: tb/fpx_exc_arbiter_tb_top.sv
`timescale 1ns/1ps
module fpx_exc_arbiter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [2:0] op_kind = '0;
    logic [2:0] cls_a = '0;
    logic       sgn_a = 1'b0;
    logic [2:0] cls_b = '0;
    logic       sgn_b = 1'b0;
    logic [7:0] dp_status = '0;
    logic [4:0] exc_enable = '0;
    logic       fpu_en = 1'b1;
    logic       unimpl = 1'b0;
    logic       trap_ack = 1'b0;
    logic       op_done_o, op_wb_o, op_qnan_o, trap_req_o, stat_err_o;
    logic [4:0] cause_o;
    logic [8:0] trap_code_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic [4:0] exp_cause = '0;

    always #2 clk = ~clk;

    fpx_exc_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .cls_a(cls_a), .sgn_a(sgn_a), .cls_b(cls_b), .sgn_b(sgn_b),
        .dp_status(dp_status), .exc_enable(exc_enable), .fpu_en(fpu_en),
        .unimpl(unimpl), .trap_ack(trap_ack), .op_done_o(op_done_o),
        .op_wb_o(op_wb_o), .op_qnan_o(op_qnan_o), .cause_o(cause_o),
        .trap_req_o(trap_req_o), .trap_code_o(trap_code_o), .stat_err_o(stat_err_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Independent reference of the rules in the brief.
    task automatic model(input int k, input int ca, input int cb, input bit sa, input bit sb,
                         input logic [7:0] st, input logic [4:0] en,
                         output bit wb, output bit qn, output logic [4:0] cs, output bit tr);
        bit inv, dz;
        inv = (ca == 4) || (cb == 4);
        if (k == 0 && ca == 2 && cb == 2 && sa != sb) inv = 1;
        if (k == 1 && ca == 2 && cb == 2 && sa == sb) inv = 1;
        if (k == 2 && ((ca == 2 && cb == 0) || (ca == 0 && cb == 2))) inv = 1;
        if (k == 3 && ((ca == 0 && cb == 0) || (ca == 2 && cb == 2))) inv = 1;
        dz = (k == 3) && (ca == 1) && (cb == 0);
        wb = 0; qn = 0; cs = 5'b0;
        if (inv) begin
            if (en[4]) cs = 5'b10000;
            else begin wb = 1; qn = 1; end
        end else if (dz && en[3]) begin
            cs = 5'b01000;
        end else begin
            if (st[0] && en[2]) cs = 5'b00100;
            else if ((st[1] || st[2]) && en[1]) cs = 5'b00010;
            else if ((st[3] || st[4]) && en[0]) cs = 5'b00001;
            wb = (cs == 0);
        end
        tr = (cs != 0);
    endtask

    task automatic run_op(input int k, input int ca, input int cb, input bit sa, input bit sb,
                          input logic [7:0] st, input logic [4:0] en, input string tag);
        bit wb, qn, tr;
        logic [4:0] cs;
        model(k, ca, cb, sa, sb, st, en, wb, qn, cs, tr);
        @(negedge clk);
        op_valid = 1; op_kind = 3'(k); cls_a = 3'(ca); cls_b = 3'(cb);
        sgn_a = sa; sgn_b = sb; dp_status = st; exc_enable = en; fpu_en = 1; unimpl = 0;
        @(negedge clk);
        op_valid = 0;
        exp_cause = cs;
        chk({tag, " R1 done"}, 32'(op_done_o), 32'd1);
        chk({tag, " R6 wb"}, 32'(op_wb_o), 32'(wb));
        chk({tag, " R3 qnan"}, 32'(op_qnan_o), 32'(qn));
        chk({tag, " R5 cause"}, 32'(cause_o), 32'(cs));
        chk({tag, " R7 trap"}, 32'(trap_req_o), 32'(tr));
        if (tr) chk({tag, " R7 code"}, 32'(trap_code_o), 32'h1D0);
        if (trap_req_o) begin
            trap_ack = 1;
            @(negedge clk);
            trap_ack = 0;
        end
    endtask

    initial begin
        while (cycles < 190000) begin
            @(posedge clk);
            cycles++;
        end
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=<190000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11-style reset state, covered by R1
        chk("R1 reset done", 32'(op_done_o), 0);
        chk("R1 reset wb", 32'(op_wb_o), 0);
        chk("R1 reset cause", 32'(cause_o), 0);
        chk("R9 reset trap", 32'(trap_req_o), 0);
        chk("R10 reset err", 32'(stat_err_o), 0);
        rst_n = 1;

        // R5/R6: every known status pattern against every enable pattern
        for (int e = 0; e < 32; e++) begin
            for (int s = 0; s < 32; s++) begin
                run_op(0, 1, 1, 0, 0, 8'(s), 5'(e), "stat");
            end
        end
        @(negedge clk);
        chk("R10 known bits leave err clear", 32'(stat_err_o), 0);

        // R2/R3/R4: classes, signs, kinds against every enable pattern
        for (int k = 0; k < 5; k++)
            for (int ca = 0; ca < 5; ca++)
                for (int cb = 0; cb < 5; cb++)
                    for (int sg = 0; sg < 4; sg++)
                        for (int e = 0; e < 32; e++)
                            run_op(k, ca, cb, sg[0], sg[1], 8'((e * 7 + ca) & 31), 5'(e), "class R2 R4");

        // Directed R4: finite/zero with Z off falls through to status, inf/0 is not Z
        run_op(3, 1, 0, 0, 0, 8'h01, 5'b00100, "R4 z off ovf");
        run_op(3, 2, 0, 0, 0, 8'h00, 5'b01000, "R4 inf over zero");

        // R8: FPU disabled, cause untouched, disabled wins over unimplemented
        run_op(0, 1, 1, 0, 0, 8'h01, 5'b00100, "R8 preset");
        @(negedge clk);
        op_valid = 1; fpu_en = 0; unimpl = 1;
        @(negedge clk);
        op_valid = 0; fpu_en = 1; unimpl = 0;
        chk("R8 off no done", 32'(op_done_o), 0);
        chk("R8 off no wb", 32'(op_wb_o), 0);
        chk("R8 off cause kept", 32'(cause_o), 32'(exp_cause));
        chk("R8 off req", 32'(trap_req_o), 1);
        chk("R8 off code", 32'(trap_code_o), 32'h1C0);

        // R9: pending trap keeps code while another trap arrives
        op_valid = 1; op_kind = 0; cls_a = 4; exc_enable = 5'b10000;
        @(negedge clk);
        op_valid = 0;
        chk("R9 held over new trap", 32'(trap_code_o), 32'h1C0);
        chk("R1 later op updates cause", 32'(cause_o), 32'h10);
        repeat (3) @(negedge clk);
        chk("R9 still held", 32'(trap_req_o), 1);
        chk("R9 code stable", 32'(trap_code_o), 32'h1C0);
        trap_ack = 1;
        @(negedge clk);
        trap_ack = 0;
        chk("R9 ack clears", 32'(trap_req_o), 0);

        // R8: unimplemented opcode with FPU on
        op_valid = 1; unimpl = 1; cls_a = 1;
        @(negedge clk);
        op_valid = 0; unimpl = 0;
        chk("R8 unimpl code", 32'(trap_code_o), 32'h1C8);
        chk("R8 unimpl no wb", 32'(op_wb_o), 0);
        chk("R8 unimpl cause kept", 32'(cause_o), 32'h10);
        trap_ack = 1;
        @(negedge clk);
        trap_ack = 0;

        // R10: unknown status bit sets a sticky flag
        run_op(0, 1, 1, 0, 0, 8'h20, 5'b00000, "R10 unknown");
        chk("R10 err set", 32'(stat_err_o), 1);
        run_op(0, 1, 1, 0, 0, 8'h00, 5'b00000, "R10 clean");
        chk("R10 err sticky", 32'(stat_err_o), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule